// File: doc/BRIEF.md
# Scalar Single-Precision Divider with Selectable Rounding

This block divides one IEEE-754 single-precision value by another over several clock cycles and returns a correctly rounded single-precision quotient with six exception flags. The caller presents the dividend, the divisor and the rounding controls together with a one-cycle `start`. The block raises `busy` while it works and pulses `done` for one cycle when the quotient and flags are valid. Both outputs hold their values until the next result is delivered.

The rounding direction is picked per operation. A 2-bit override field carried with the operation is used only when the override enable is set and the divisor comes from a register. Otherwise the 2-bit field of the global control register is used. Zeros, infinities, NaNs and subnormal operands are all handled. The quotient mantissa comes from a restoring divider that produces one bit per cycle. Results that are too small are shifted into subnormal form before rounding. Results that are too large saturate according to the rounding direction.

Top module: `fpdiv_top`

## Requirements
- R1: For finite, nonzero operands the result is the quotient of `op_a` divided by `op_b`, rounded to single precision. An exact quotient raises no flag.
- R2: The rounding field in use is `ovr_rnd` when `ovr_en` is 1 and `divisor_is_reg` is 1. In every other combination it is `glb_rnd`.
- R3: Rounding field codes: 00 nearest with ties to even, 01 toward minus infinity, 10 toward plus infinity, 11 toward zero. Any inexact result sets `flags[5]` (precision).
- R4: Zero divided by zero and infinity divided by infinity return 0xFFC00000 and set `flags[0]` (invalid).
- R5: A NaN operand is returned with bit 22 forced to 1. When both operands are NaN, the dividend's NaN is returned. `flags[0]` is set only if at least one operand is a signaling NaN, meaning bit 22 is 0.
- R6: A finite nonzero value divided by a zero of either sign returns infinity, with the sign equal to the XOR of the operand signs, and sets `flags[2]` (divide-by-zero).
- R7: Infinity divided by a finite value returns infinity. A finite value divided by infinity, and zero divided by a finite nonzero value, return zero. The sign is the XOR of the operand signs, and no flag is set.
- R8: On overflow `flags[3]` and `flags[5]` are both set. The result is infinity for nearest. For toward-zero it is the largest finite magnitude 0x7F7FFFFF with the result's sign. For the two directed modes it is infinity when rounding away from zero and the largest finite magnitude otherwise.
- R9: A result whose magnitude before rounding lies below 2^-126 is shifted to subnormal form and then rounded. `flags[4]` (underflow) is set only when such a result is also inexact.
- R10: `flags[1]` (denormal operand) is set whenever either operand is subnormal, meaning a zero exponent field with a nonzero fraction. Subnormal operands are divided at full accuracy.
- R11: `busy` is 1 from the cycle after an accepted `start` until the result arrives. `done` is a one-cycle pulse with `busy` at 0. `start` while `busy` is ignored. `quotient` and `flags` change only in a `done` cycle.
- R12: After a synchronous reset `busy`, `done`, `quotient` and `flags` are all 0, even if reset arrives in the middle of an operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only when not busy |
| op_a | input | 32 | Dividend, single precision |
| op_b | input | 32 | Divisor, single precision |
| divisor_is_reg | input | 1 | Divisor comes from a register (1) or from memory (0) |
| ovr_en | input | 1 | Request the per-operation rounding override |
| ovr_rnd | input | 2 | Per-operation rounding field |
| glb_rnd | input | 2 | Rounding field of the global control register |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle result-valid strobe |
| quotient | output | 32 | Rounded quotient |
| flags | output | 6 | [0] invalid, [1] denormal, [2] divide-by-zero, [3] overflow, [4] underflow, [5] precision |

## Verification
The assertions assume that `start` is only offered as a single-cycle request. The bench always drops it on the next negative edge, except in the one test that deliberately holds it high while the block is busy. The iteration invariant in the mantissa divider assumes the divisor mantissa has its top bit set. This holds because only finite nonzero operands, which have been normalized, reach the divider. The bench tests special values only through the classification path, so the divider never receives a zero divisor. The bench drives inputs at the falling edge and reads outputs at the falling edge, and it changes rounding controls only alongside `start`.

// File: rtl/fpdiv_pkg.sv
// Package: shared constants and types for the single-precision divider.
// Assumes IEEE-754 binary32 layout (1 sign, 8 exponent, 23 fraction bits).
package fpdiv_pkg;
    localparam int FP_W    = 32;
    localparam int EXP_W   = 8;
    localparam int FRAC_W  = 23;
    localparam int MANT_W  = FRAC_W + 1;
    localparam int BIAS    = 127;
    localparam int QUO_W   = MANT_W + 2;           // quotient bits incl. normalise + guard
    localparam int EXP_IW  = EXP_W + 3;            // signed internal exponent width
    localparam int CNT_W   = $clog2(QUO_W + 1);
    localparam int LZ_W    = $clog2(MANT_W + 1);
    localparam int NFLAGS  = 6;

    localparam int FL_IE = 0;
    localparam int FL_DE = 1;
    localparam int FL_ZE = 2;
    localparam int FL_OE = 3;
    localparam int FL_UE = 4;
    localparam int FL_PE = 5;

    localparam logic [FP_W-1:0] DEFAULT_QNAN = 32'hFFC0_0000;
    localparam logic [FP_W-1:0] QUIET_BIT    = 32'h0040_0000;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_DOWN = 2'b01,
        RM_UP   = 2'b10,
        RM_ZERO = 2'b11
    } rmode_e;

    typedef struct packed {
        logic                     sign;
        logic signed [EXP_IW-1:0] exp;   // unbiased exponent of normalised mantissa
        logic [MANT_W-1:0]        mant;  // 1.xxx form, top bit set when finite nonzero
        logic                     is_zero;
        logic                     is_inf;
        logic                     is_nan;
        logic                     is_snan;
        logic                     is_sub;
    } opnd_t;
endpackage

// File: rtl/fpdiv_unpack.sv
// Module: classifies one binary32 operand and produces a normalised mantissa
// and unbiased exponent. Subnormal inputs are left-shifted so the mantissa's
// top bit is set. Purely combinational.
module fpdiv_unpack
    import fpdiv_pkg::*;
(
    input  logic [FP_W-1:0] raw,
    output opnd_t           op
);
    logic [EXP_W-1:0]  ef;
    logic [FRAC_W-1:0] fr;
    logic [MANT_W-1:0] padded;
    logic [LZ_W-1:0]   lz;
    logic              found;

    // Count leading zeros of the zero-extended fraction (subnormal normalisation).
    always_comb begin
        ef     = raw[FP_W-2 -: EXP_W];
        fr     = raw[FRAC_W-1:0];
        padded = {1'b0, fr};
        lz     = '0;
        found  = 1'b0;
        for (int i = MANT_W - 1; i >= 0; i--) begin
            if (!found) begin
                if (padded[i]) found = 1'b1;
                else           lz    = lz + 1'b1;
            end
        end
    end

    // Classify and build the normalised operand record.
    always_comb begin
        op.sign    = raw[FP_W-1];
        op.is_zero = (ef == '0) && (fr == '0);
        op.is_sub  = (ef == '0) && (fr != '0);
        op.is_inf  = (ef == '1) && (fr == '0);
        op.is_nan  = (ef == '1) && (fr != '0);
        op.is_snan = op.is_nan && !fr[FRAC_W-1];
        if (op.is_sub) begin
            op.mant = padded << lz;
            op.exp  = $signed(EXP_IW'(1 - BIAS)) - $signed({{(EXP_IW-LZ_W){1'b0}}, lz});
        end else begin
            op.mant = {1'b1, fr};
            op.exp  = $signed({{(EXP_IW-EXP_W){1'b0}}, ef}) - $signed(EXP_IW'(BIAS));
        end
    end
endmodule

// File: rtl/fpdiv_rmsel.sv
// Module: picks the rounding direction for one operation. The per-operation
// field wins only when requested and the divisor is a register operand.
module fpdiv_rmsel
    import fpdiv_pkg::*;
(
    input  logic       divisor_is_reg,
    input  logic       ovr_en,
    input  logic [1:0] ovr_rnd,
    input  logic [1:0] glb_rnd,
    output rmode_e     rm
);
    // Select between the override field and the global field.
    always_comb begin
        if (ovr_en && divisor_is_reg) rm = rmode_e'(ovr_rnd);
        else                          rm = rmode_e'(glb_rnd);
    end
endmodule

// File: rtl/fpdiv_iter.sv
// Module: radix-2 restoring mantissa divider, one quotient bit per cycle.
// Assumes the divisor mantissa has its top bit set (normalised, nonzero).
// After 'load', QUO_W iterations run; 'last' marks the final iteration and the
// quotient/remainder are valid from the following cycle.
module fpdiv_iter
    import fpdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MANT_W-1:0] dividend,
    input  logic [MANT_W-1:0] divisor,
    output logic [QUO_W-1:0]  q,
    output logic              rem_nz,
    output logic              last
);
    logic [QUO_W-1:0]  rem;
    logic [MANT_W-1:0] div_q;
    logic [CNT_W-1:0]  cnt;
    logic              active;
    logic [QUO_W-1:0]  div_ext;

    assign div_ext = {{(QUO_W-MANT_W){1'b0}}, div_q};
    assign rem_nz  = |rem;
    assign last    = active && (cnt == CNT_W'(QUO_W - 1));

    // Shift-subtract iteration with restoring compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem    <= '0;
            div_q  <= '0;
            q      <= '0;
            cnt    <= '0;
            active <= 1'b0;
        end else if (load) begin
            rem    <= {{(QUO_W-MANT_W){1'b0}}, dividend};
            div_q  <= divisor;
            q      <= '0;
            cnt    <= '0;
            active <= 1'b1;
        end else if (active) begin
            if (rem >= div_ext) begin
                q   <= {q[QUO_W-2:0], 1'b1};
                rem <= (rem - div_ext) << 1;
            end else begin
                q   <= {q[QUO_W-2:0], 1'b0};
                rem <= rem << 1;
            end
            cnt <= cnt + 1'b1;
            if (last) active <= 1'b0;
        end
    end

    // R1: the partial remainder never reaches twice the divisor while iterating.
    p_rem_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rem < {div_ext[QUO_W-2:0], 1'b0}));
endmodule

// File: rtl/fpdiv_round.sv
// Module: rounds a normalised 24-bit significand with guard and sticky bits to
// binary32. Handles denormalisation of tiny results before rounding and
// saturation on overflow. Purely combinational.
module fpdiv_round
    import fpdiv_pkg::*;
(
    input  logic                     sign,
    input  logic signed [EXP_IW-1:0] be,     // biased exponent before rounding
    input  logic [MANT_W-1:0]        sig,
    input  logic                     guard,
    input  logic                     sticky,
    input  rmode_e                   rm,
    output logic [FP_W-1:0]          res,
    output logic                     of,
    output logic                     uf,
    output logic                     pe
);
    localparam int VW = 2 * MANT_W + 2;                   // shift window
    localparam int SH_MAX = MANT_W + 2;
    localparam logic signed [EXP_IW-1:0] EXP_TOP = EXP_IW'(254);

    logic                     tiny;
    logic signed [EXP_IW-1:0] shv;
    logic [LZ_W-1:0]          sh;
    logic [VW-1:0]            v, sv;
    logic [MANT_W-1:0]        s2;
    logic                     g2, t2, inexact, inc, to_inf;
    logic [MANT_W:0]          sum;
    logic signed [EXP_IW-1:0] eo;

    // Denormalise tiny results, collecting shifted-out bits into sticky.
    always_comb begin
        tiny = be[EXP_IW-1] || (be == '0);
        shv  = EXP_IW'(1) - be;
        sh   = (shv > EXP_IW'(SH_MAX)) ? LZ_W'(SH_MAX) : shv[LZ_W-1:0];
        v    = {sig, guard, {(VW-MANT_W-1){1'b0}}};
        sv   = v >> sh;
        if (tiny) begin
            s2 = sv[VW-1 -: MANT_W];
            g2 = sv[VW-MANT_W-1];
            t2 = sticky || (|sv[VW-MANT_W-2:0]) || ((sv << sh) != v);
        end else begin
            s2 = sig;
            g2 = guard;
            t2 = sticky;
        end
    end

    // Round-increment decision and overflow/packing.
    always_comb begin
        inexact = g2 | t2;
        unique case (rm)
            RM_NEAR: inc = g2 & (t2 | s2[0]);
            RM_DOWN: inc = sign & inexact;
            RM_UP:   inc = ~sign & inexact;
            default: inc = 1'b0;
        endcase
        to_inf = (rm == RM_NEAR) || (rm == RM_UP && !sign) || (rm == RM_DOWN && sign);
        sum    = {1'b0, s2} + {{MANT_W{1'b0}}, inc};
        eo     = be + {{(EXP_IW-1){1'b0}}, sum[MANT_W]};
        of     = 1'b0;
        uf     = 1'b0;
        pe     = inexact;
        if (tiny) begin
            res = {sign, {(EXP_W-1){1'b0}}, sum[MANT_W-1], sum[FRAC_W-1:0]};
            uf  = inexact;
        end else if (eo > EXP_TOP) begin
            of  = 1'b1;
            pe  = 1'b1;
            res = to_inf ? {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                         : {sign, {(EXP_W-1){1'b1}}, 1'b0, {FRAC_W{1'b1}}};
        end else if (sum[MANT_W]) begin
            res = {sign, eo[EXP_W-1:0], {FRAC_W{1'b0}}};
        end else begin
            res = {sign, eo[EXP_W-1:0], sum[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fpdiv_top.sv
// Module: multi-cycle binary32 divider with per-operation rounding selection.
// Sequence: IDLE -> PREP (classify; special values finish here) -> CALC
// (mantissa iteration) -> FIN (round, deliver). Assumes 'start' is a request
// sampled only in IDLE; outputs hold until the next 'done'.
module fpdiv_top
    import fpdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FP_W-1:0]   op_a,
    input  logic [FP_W-1:0]   op_b,
    input  logic              divisor_is_reg,
    input  logic              ovr_en,
    input  logic [1:0]        ovr_rnd,
    input  logic [1:0]        glb_rnd,
    output logic              busy,
    output logic              done,
    output logic [FP_W-1:0]   quotient,
    output logic [NFLAGS-1:0] flags
);
    typedef enum logic [1:0] {S_IDLE, S_PREP, S_CALC, S_FIN} state_e;

    localparam logic signed [EXP_IW-1:0] BIAS_HI = EXP_IW'(BIAS);
    localparam logic signed [EXP_IW-1:0] BIAS_LO = EXP_IW'(BIAS - 1);

    state_e                   state;
    logic [FP_W-1:0]          raw_q [2];
    opnd_t                    opnd  [2];
    rmode_e                   rm_sel, rm_q;
    logic signed [EXP_IW-1:0] ediff_q;
    logic                     sign_q, den_q;

    logic                     sp_hit;
    logic [FP_W-1:0]          sp_res;
    logic [NFLAGS-1:0]        sp_flags;
    logic                     res_sign, any_den;

    logic [QUO_W-1:0]         iq;
    logic                     irem_nz, ilast, iload;

    logic [MANT_W-1:0]        n_sig;
    logic                     n_g, n_t;
    logic signed [EXP_IW-1:0] n_be;
    logic [FP_W-1:0]          r_res;
    logic                     r_of, r_uf, r_pe;

    // One classifier per operand.
    for (genvar k = 0; k < 2; k++) begin : g_unpack
        fpdiv_unpack u_unpack (.raw(raw_q[k]), .op(opnd[k]));
    end

    fpdiv_rmsel u_rmsel (
        .divisor_is_reg (divisor_is_reg),
        .ovr_en         (ovr_en),
        .ovr_rnd        (ovr_rnd),
        .glb_rnd        (glb_rnd),
        .rm             (rm_sel)
    );

    assign res_sign = opnd[0].sign ^ opnd[1].sign;
    assign any_den  = opnd[0].is_sub | opnd[1].is_sub;

    // Special-value resolution (NaN, invalid, infinities, zeros).
    always_comb begin
        sp_hit   = 1'b1;
        sp_flags = '0;
        sp_flags[FL_DE] = any_den;
        sp_res   = '0;
        if (opnd[0].is_nan || opnd[1].is_nan) begin
            sp_res = (opnd[0].is_nan ? raw_q[0] : raw_q[1]) | QUIET_BIT;
            sp_flags[FL_IE] = opnd[0].is_snan | opnd[1].is_snan;
        end else if ((opnd[0].is_zero && opnd[1].is_zero) ||
                     (opnd[0].is_inf && opnd[1].is_inf)) begin
            sp_res = DEFAULT_QNAN;
            sp_flags[FL_IE] = 1'b1;
        end else if (opnd[0].is_inf) begin
            sp_res = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (opnd[1].is_inf || opnd[0].is_zero) begin
            sp_res = {res_sign, {(FP_W-1){1'b0}}};
        end else if (opnd[1].is_zero) begin
            sp_res = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            sp_flags[FL_ZE] = 1'b1;
        end else begin
            sp_hit = 1'b0;
        end
    end

    assign iload = (state == S_PREP) && !sp_hit;

    fpdiv_iter u_iter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (iload),
        .dividend (opnd[0].mant),
        .divisor  (opnd[1].mant),
        .q        (iq),
        .rem_nz   (irem_nz),
        .last     (ilast)
    );

    // Normalise the raw quotient to 24 bits plus guard and sticky.
    always_comb begin
        if (iq[QUO_W-1]) begin
            n_sig = iq[QUO_W-1 -: MANT_W];
            n_g   = iq[1];
            n_t   = iq[0] | irem_nz;
            n_be  = ediff_q + BIAS_HI;
        end else begin
            n_sig = iq[QUO_W-2 -: MANT_W];
            n_g   = iq[0];
            n_t   = irem_nz;
            n_be  = ediff_q + BIAS_LO;
        end
    end

    fpdiv_round u_round (
        .sign   (sign_q),
        .be     (n_be),
        .sig    (n_sig),
        .guard  (n_g),
        .sticky (n_t),
        .rm     (rm_q),
        .res    (r_res),
        .of     (r_of),
        .uf     (r_uf),
        .pe     (r_pe)
    );

    assign busy = (state != S_IDLE);

    // Control sequence, operand capture and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            raw_q[0] <= '0;
            raw_q[1] <= '0;
            rm_q     <= RM_NEAR;
            ediff_q  <= '0;
            sign_q   <= 1'b0;
            den_q    <= 1'b0;
            done     <= 1'b0;
            quotient <= '0;
            flags    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: if (start) begin
                    raw_q[0] <= op_a;
                    raw_q[1] <= op_b;
                    rm_q     <= rm_sel;
                    state    <= S_PREP;
                end
                S_PREP: begin
                    if (sp_hit) begin
                        quotient <= sp_res;
                        flags    <= sp_flags;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        ediff_q <= opnd[0].exp - opnd[1].exp;
                        sign_q  <= res_sign;
                        den_q   <= any_den;
                        state   <= S_CALC;
                    end
                end
                S_CALC: if (ilast) state <= S_FIN;
                default: begin
                    quotient <= r_res;
                    flags    <= '0;
                    flags[FL_DE] <= den_q;
                    flags[FL_OE] <= r_of;
                    flags[FL_UE] <= r_uf;
                    flags[FL_PE] <= r_pe;
                    done     <= 1'b1;
                    state    <= S_IDLE;
                end
            endcase
        end
    end

    // R11: done lasts exactly one cycle.
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: busy is low whenever a result is delivered.
    p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R11: an accepted start makes the block busy on the next cycle.
    p_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R11: outputs change only together with done.
    p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !done) |-> ($stable(quotient) && $stable(flags)));
    // R6: divide-by-zero always comes with an infinite result.
    p_dz_inf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[FL_ZE]) |-> (quotient[FP_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));
    // R8: overflow is always reported with precision.
    p_of_pe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[FL_OE]) |-> flags[FL_PE]);
    // R9: underflow is only reported for inexact results.
    p_uf_pe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags[FL_UE]) |-> flags[FL_PE]);
endmodule

// File: tb/test_fpdiv_top.sv
module test_fpdiv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        divisor_is_reg = 1'b1;
    logic        ovr_en = 1'b0;
    logic [1:0]  ovr_rnd = 2'b00;
    logic [1:0]  glb_rnd = 2'b00;
    logic        busy, done;
    logic [31:0] quotient;
    logic [5:0]  flags;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    fpdiv_top i_fpdiv_top (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .divisor_is_reg(divisor_is_reg), .ovr_en(ovr_en), .ovr_rnd(ovr_rnd),
        .glb_rnd(glb_rnd), .busy(busy), .done(done), .quotient(quotient), .flags(flags)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic        reg_src;
        logic        en;
        logic [1:0]  ovr;
        logic [1:0]  glb;
        logic [31:0] q;
        logic [5:0]  fl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 38;
    // Rounding codes: 0 nearest, 1 down, 2 up, 3 toward zero.
    // Flags: [0] IE [1] DE [2] ZE [3] OE [4] UE [5] PE.
    localparam vec_t VECS [NV] = '{
        '{32'h40C00000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h40000000, 6'h00, 8'd1},  // R1 6/3
        '{32'h3F800000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h3EAAAAAB, 6'h20, 8'd1},  // R1 1/3
        '{32'h3F800000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd3, 32'h3EAAAAAA, 6'h20, 8'd3},  // R3 RZ
        '{32'h3F800000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd1, 32'h3EAAAAAA, 6'h20, 8'd3},  // R3 down
        '{32'h3F800000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd2, 32'h3EAAAAAB, 6'h20, 8'd3},  // R3 up
        '{32'hBF800000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd1, 32'hBEAAAAAB, 6'h20, 8'd3},  // R3 neg down
        '{32'hBF800000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd2, 32'hBEAAAAAA, 6'h20, 8'd3},  // R3 neg up
        '{32'h3F800000, 32'h40400000, 1'b1, 1'b1, 2'd3, 2'd0, 32'h3EAAAAAA, 6'h20, 8'd2},  // R2 override used
        '{32'h3F800000, 32'h40400000, 1'b0, 1'b1, 2'd3, 2'd0, 32'h3EAAAAAB, 6'h20, 8'd2},  // R2 memory source
        '{32'h3F800000, 32'h40400000, 1'b1, 1'b0, 2'd3, 2'd0, 32'h3EAAAAAB, 6'h20, 8'd2},  // R2 not requested
        '{32'h3F800000, 32'h40400000, 1'b1, 1'b1, 2'd0, 2'd3, 32'h3EAAAAAB, 6'h20, 8'd2},  // R2 override nearest
        '{32'h00000000, 32'h00000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'hFFC00000, 6'h01, 8'd4},  // R4 0/0
        '{32'h7F800000, 32'hFF800000, 1'b1, 1'b0, 2'd0, 2'd0, 32'hFFC00000, 6'h01, 8'd4},  // R4 inf/inf
        '{32'h7F800001, 32'h3F800000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7FC00001, 6'h01, 8'd5},  // R5 sNaN a
        '{32'h7FC00005, 32'h3F800000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7FC00005, 6'h00, 8'd5},  // R5 qNaN a
        '{32'h3F800000, 32'hFF800002, 1'b1, 1'b0, 2'd0, 2'd0, 32'hFFC00002, 6'h01, 8'd5},  // R5 sNaN b
        '{32'h7FC00000, 32'h7F800001, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7FC00000, 6'h01, 8'd5},  // R5 both NaN
        '{32'h3F800000, 32'h00000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7F800000, 6'h04, 8'd6},  // R6
        '{32'hBF800000, 32'h00000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'hFF800000, 6'h04, 8'd6},  // R6 neg
        '{32'h3F800000, 32'h80000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'hFF800000, 6'h04, 8'd6},  // R6 -0
        '{32'h7F800000, 32'h40000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7F800000, 6'h00, 8'd7},  // R7 inf/2
        '{32'h40000000, 32'hFF800000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h80000000, 6'h00, 8'd7},  // R7 2/-inf
        '{32'h00000000, 32'hC0400000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h80000000, 6'h00, 8'd7},  // R7 0/-3
        '{32'h7F7FFFFF, 32'h3F000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7F800000, 6'h28, 8'd8},  // R8 nearest
        '{32'h7F7FFFFF, 32'h3F000000, 1'b1, 1'b0, 2'd0, 2'd3, 32'h7F7FFFFF, 6'h28, 8'd8},  // R8 RZ
        '{32'hFF7FFFFF, 32'h3F000000, 1'b1, 1'b0, 2'd0, 2'd2, 32'hFF7FFFFF, 6'h28, 8'd8},  // R8 neg up
        '{32'hFF7FFFFF, 32'h3F000000, 1'b1, 1'b0, 2'd0, 2'd1, 32'hFF800000, 6'h28, 8'd8},  // R8 neg down
        '{32'h00800000, 32'h40000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h00400000, 6'h00, 8'd9},  // R9 tiny exact
        '{32'h00800000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h002AAAAB, 6'h30, 8'd9},  // R9 tiny inexact
        '{32'h00800000, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd3, 32'h002AAAAA, 6'h30, 8'd9},  // R9 RZ
        '{32'h00000001, 32'h3F000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h00000002, 6'h02, 8'd10}, // R10
        '{32'h00000003, 32'h40400000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h00000001, 6'h02, 8'd10}, // R10
        '{32'h3F800000, 32'h00000001, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7F800000, 6'h2A, 8'd10}, // R10 overflow
        '{32'h00000001, 32'h40000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h00000000, 6'h32, 8'd9},  // R9 tie to even 0
        '{32'h00000001, 32'h40000000, 1'b1, 1'b0, 2'd0, 2'd2, 32'h00000001, 6'h32, 8'd9},  // R9 up
        '{32'h00000003, 32'h40000000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h00000002, 6'h32, 8'd9},  // R9 tie to even 2
        '{32'h00000001, 32'h7FC00000, 1'b1, 1'b0, 2'd0, 2'd0, 32'h7FC00000, 6'h02, 8'd10}, // R10 with NaN
        '{32'h00000002, 32'h00000001, 1'b1, 1'b0, 2'd0, 2'd0, 32'h40000000, 6'h02, 8'd10}  // R10 sub/sub
    };

    task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input vec_t v, output logic [31:0] q, output logic [5:0] f, output logic seen);
        @(negedge clk);
        op_a = v.a; op_b = v.b; divisor_is_reg = v.reg_src;
        ovr_en = v.en; ovr_rnd = v.ovr; glb_rnd = v.glb; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < 80 && !seen; c++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
        q = quotient;
        f = flags;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] q;
        logic [5:0]  f;
        logic        seen;
        int          pulses;

        repeat (3) @(negedge clk);
        // R12: reset state
        chk(12, "busy after reset", {31'b0, busy}, 32'd0);
        chk(12, "done after reset", {31'b0, done}, 32'd0);
        chk(12, "quotient after reset", quotient, 32'd0);
        chk(12, "flags after reset", {26'b0, flags}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i], q, f, seen);
            chk(11, $sformatf("vector %0d done seen", i), {31'b0, seen}, 32'd1);
            chk(int'(VECS[i].req), $sformatf("vector %0d quotient", i), q, VECS[i].q);
            chk(int'(VECS[i].req), $sformatf("vector %0d flags", i), {26'b0, f}, {26'b0, VECS[i].fl});
        end

        // R11: busy while running, start ignored while busy, single done pulse.
        @(negedge clk);
        op_a = 32'h3F800000; op_b = 32'h40400000; divisor_is_reg = 1'b1;
        ovr_en = 1'b0; glb_rnd = 2'd0; start = 1'b1;
        @(negedge clk);
        chk(11, "busy after start", {31'b0, busy}, 32'd1);
        op_a = 32'h40C00000; glb_rnd = 2'd3;   // new request while busy: must be ignored
        repeat (3) @(negedge clk);
        start = 1'b0;
        pulses = 0;
        for (int c = 0; c < 80 && pulses == 0; c++) begin
            if (done) begin
                pulses++;
                chk(11, "busy low with done", {31'b0, busy}, 32'd0);
                chk(11, "result of first request", quotient, 32'h3EAAAAAB);
            end else @(negedge clk);
        end
        chk(11, "done observed", pulses, 1);
        @(negedge clk);
        chk(11, "done lasts one cycle", {31'b0, done}, 32'd0);
        chk(11, "no second operation started", {31'b0, busy}, 32'd0);
        repeat (5) @(negedge clk);
        chk(11, "quotient held", quotient, 32'h3EAAAAAB);
        chk(11, "flags held", {26'b0, flags}, 32'h20);

        // R12: reset in the middle of an operation.
        @(negedge clk);
        op_a = 32'h3F800000; op_b = 32'h40400000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(12, "busy after mid-run reset", {31'b0, busy}, 32'd0);
        chk(12, "quotient after mid-run reset", quotient, 32'd0);
        chk(12, "flags after mid-run reset", {26'b0, flags}, 32'd0);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(12, "no late done after reset", {31'b0, done}, 32'd0);
        chk(12, "quotient still cleared", quotient, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule